// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is the counting engine that sits behind one processor's timer window. It runs in one of two personalities. In counter mode it behaves as a limit-match timer. The count climbs from zero in steps of 0x200, and when it would reach the programmed limit it wraps to zero, sets a reached flag and raises an interrupt line. Reading the limit word acknowledges the event. In user mode the same storage becomes a 63-bit counter that software starts and stops. Software sees it as an upper word and a lower word and can load either one, and this mode never interrupts.

The personality comes from outside. A shared mode register elsewhere on the chip owns the bit for this processor. It delivers the bit together with a change strobe, and this block applies the side effects of a real change at that moment. The tick that advances the count also comes from a prescaler outside the block. A parameter selects the system-timer variant, which never leaves counter mode and hides the run word. Register access is a single-cycle word bus: reads are combinational, and writes and read side effects take effect at the clock edge.

Top module: `dual_mode_cpu_timer`

## Requirements
- R1: After reset the block is in counter mode with count 0, limit 0, run bit 1, reached flag 0 and the interrupt low.
- R2: In counter mode every cycle with `tick_i` high adds 0x200 to the count, whatever the run bit holds. Reading word 1 returns {reached, count[30:0]}.
- R3: In counter mode, when the count plus 0x200 reaches or passes a nonzero limit, the count returns to 0, the reached flag is set and `irq_o` rises on the same edge. With limit 0 the count wraps after 0x7FFFFE00 and neither the flag nor the interrupt is ever set.
- R4: In counter mode, writing word 0 stores wdata & 0x7FFFFE00 as the limit, clears the count and lowers `irq_o`.
- R5: In counter mode, reading word 0 returns the limit and clears the reached flag and the interrupt at that edge. If a limit match falls in the same cycle, the flag and the interrupt stay set.
- R6: In counter mode, writing word 2 replaces the limit (masked with 0x7FFFFE00) and leaves the count unchanged. Writing word 1 has no effect.
- R7: In user mode, reading word 0 returns {reached, count[62:32]} and reading word 1 returns count[31:0]. Neither read changes any state.
- R8: In user mode, writing word 0 loads count[62:32] from wdata[30:0], and writing word 1 loads count[31:0] from wdata & 0xFFFFFE00. Either write clears the reached flag, and counting resumes from the composed value.
- R9: In user mode the count advances by 0x200 per tick only while the run bit is 1, with the carry passing from the lower word into the upper word. At 0x7FFFFFFFFFFFFE00 it wraps to 0 and sets the reached flag. `irq_o` stays low in user mode.
- R10: Bit 0 of word 3 is the run bit and can be read and written. On the system-timer variant word 3 reads 0 and the mode strobe is ignored.
- R11: A change from counter to user mode lowers `irq_o`, clears the count, the reached flag and the stored limit, and keeps the run bit. A run bit of 0 therefore leaves the counter halted.
- R12: A change from user to counter mode sets the run bit to 1, clears the count and the reached flag, and counting on ticks resumes.
- R13: A mode strobe whose bit equals the current mode has no effect. Writes to word 4 have no effect.
- R14: When a register write and a tick fall in the same cycle, the written value wins. In counter mode a word 0 write with a tick leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable pulse from the prescaler |
| mode_stb_i | input | 1 | Strobe: a new mode bit is presented |
| mode_bit_i | input | 1 | Requested mode, 1 = user, 0 = counter |
| bus_wr_i | input | 1 | Register write enable |
| bus_rd_i | input | 1 | Register read enable (used for read side effects) |
| bus_word_i | input | 3 | Word index of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Limit-match interrupt |
| user_mode_o | output | 1 | Current mode, 1 = user |

## Verification
A tick that completes a limit match can land in the same cycle as the read of word 0, and that read is the acknowledge. The bench provokes this by holding the tick and the read together on the matching cycle. It then judges that the read returned the limit and that `irq_o` and the reached flag are still set afterwards, so the new event is not lost. A second collision pairs a limit write with a tick, and the count read back must be 0.

// File: rtl/dmt_pkg.sv
`timescale 1ns/1ps
package dmt_pkg;
    localparam int WORD_AW = 3;

    typedef enum logic [WORD_AW-1:0] {
        WD_LIMHI   = 3'd0,
        WD_CNTLO   = 3'd1,
        WD_LIMSOFT = 3'd2,
        WD_RUN     = 3'd3,
        WD_MODE    = 3'd4
    } word_e;
endpackage

// File: rtl/dmt_advance.sv
`timescale 1ns/1ps
module dmt_advance #(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 9
) (
    input  logic [2*DATA_W-2:0] cnt_i,
    input  logic [DATA_W-1:0]   limit_i,
    input  logic                user_i,
    output logic [2*DATA_W-2:0] nxt_o,
    output logic                flag_o,
    output logic                raise_o
);
    localparam int CNT_W = 2*DATA_W - 1;
    localparam logic [CNT_W:0]    STEP    = (CNT_W+1)'(1) << FRAC_W;
    localparam logic [CNT_W-1:0]  USR_MAX = {{(CNT_W-FRAC_W){1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [DATA_W-1:0] CTR_MAX = {1'b0, {(DATA_W-1-FRAC_W){1'b1}}, {FRAC_W{1'b0}}};

    logic [CNT_W:0] sum;
    logic [CNT_W:0] lim;
    logic           hit;
    logic           lim_set;

    always_comb begin
        sum     = {1'b0, cnt_i} + STEP;
        lim_set = (limit_i != '0);
        lim     = '0;
        if (user_i) begin
            lim = {1'b0, USR_MAX};
        end else begin
            lim[DATA_W-1:0] = lim_set ? limit_i : CTR_MAX;
        end
        hit     = (sum >= lim);
        nxt_o   = hit ? '0 : sum[CNT_W-1:0];
        flag_o  = hit && (user_i || lim_set);
        raise_o = hit && !user_i && lim_set;
    end
endmodule

// File: rtl/dmt_rdmux.sv
`timescale 1ns/1ps
module dmt_rdmux
    import dmt_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit SYSTEM_TIMER = 1'b0
) (
    input  logic [WORD_AW-1:0]  word_i,
    input  logic                user_i,
    input  logic [2*DATA_W-2:0] cnt_i,
    input  logic [DATA_W-1:0]   limit_i,
    input  logic                reached_i,
    input  logic                run_i,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int CNT_W = 2*DATA_W - 1;

    logic [DATA_W-1:0] run_word;

    generate
        if (SYSTEM_TIMER) begin : g_sys
            assign run_word = '0;
            logic unused_run;
            assign unused_run = run_i;
        end else begin : g_cpu
            assign run_word = {{(DATA_W-1){1'b0}}, run_i};
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        case (word_i)
            WD_LIMHI: rdata_o = user_i ? {reached_i, cnt_i[CNT_W-1:DATA_W]} : limit_i;
            WD_CNTLO: rdata_o = user_i ? cnt_i[DATA_W-1:0]
                                       : {reached_i, cnt_i[DATA_W-2:0]};
            WD_RUN:   rdata_o = run_word;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dual_mode_cpu_timer.sv
`timescale 1ns/1ps
module dual_mode_cpu_timer
    import dmt_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int FRAC_W       = 9,
    parameter bit SYSTEM_TIMER = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              mode_stb_i,
    input  logic              mode_bit_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [WORD_AW-1:0] bus_word_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              user_mode_o
);
    localparam int CNT_W = 2*DATA_W - 1;
    localparam logic [DATA_W-1:0] LIM_MASK = {1'b0, {(DATA_W-1-FRAC_W){1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [DATA_W-1:0] LO_MASK  = {{(DATA_W-FRAC_W){1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] limit;
        logic              reached;
        logic              irq;
        logic              run;
        logic              user;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] adv_nxt;
    logic             adv_flag;
    logic             adv_raise;
    logic             mode_take;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    dmt_advance #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_adv (
        .cnt_i   (st_q.cnt),
        .limit_i (st_q.limit),
        .user_i  (st_q.user),
        .nxt_o   (adv_nxt),
        .flag_o  (adv_flag),
        .raise_o (adv_raise)
    );

    dmt_rdmux #(.DATA_W(DATA_W), .SYSTEM_TIMER(SYSTEM_TIMER)) u_rd (
        .word_i    (bus_word_i),
        .user_i    (st_q.user),
        .cnt_i     (st_q.cnt),
        .limit_i   (st_q.limit),
        .reached_i (st_q.reached),
        .run_i     (st_q.run),
        .rdata_o   (bus_rdata_o)
    );

    generate
        if (SYSTEM_TIMER) begin : g_sys_mode
            assign mode_take = 1'b0;
            logic unused_mode;
            assign unused_mode = mode_stb_i ^ mode_bit_i;
        end else begin : g_cpu_mode
            assign mode_take = mode_stb_i && (mode_bit_i != st_q.user);
        end
    endgenerate

    always_comb begin
        st_d = st_q;

        // acknowledge through a limit read (counter mode only)
        if (bus_rd_i && !st_q.user && (bus_word_i == WD_LIMHI)) begin
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end

        // advance; a new match overrides the acknowledge
        if (tick_i && (!st_q.user || st_q.run)) begin
            st_d.cnt = adv_nxt;
            if (adv_flag)  st_d.reached = 1'b1;
            if (adv_raise) st_d.irq     = 1'b1;
        end

        // register writes win over the tick
        if (bus_wr_i) begin
            case (bus_word_i)
                WD_LIMHI: begin
                    if (st_q.user) begin
                        st_d.cnt[CNT_W-1:DATA_W] = bus_wdata_i[DATA_W-2:0];
                        st_d.reached             = 1'b0;
                    end else begin
                        st_d.limit = bus_wdata_i & LIM_MASK;
                        st_d.cnt   = '0;
                        st_d.irq   = 1'b0;
                    end
                end
                WD_CNTLO: begin
                    if (st_q.user) begin
                        st_d.cnt[DATA_W-1:0] = bus_wdata_i & LO_MASK;
                        st_d.reached         = 1'b0;
                    end
                end
                WD_LIMSOFT: begin
                    if (!st_q.user) st_d.limit = bus_wdata_i & LIM_MASK;
                end
                WD_RUN:  st_d.run = bus_wdata_i[0];
                default: ;
            endcase
        end

        // mode change side effects take priority over everything
        if (mode_take) begin
            st_d.cnt     = '0;
            st_d.reached = 1'b0;
            if (mode_bit_i) begin
                st_d.user  = 1'b1;
                st_d.irq   = 1'b0;
                st_d.limit = '0;
            end else begin
                st_d.user = 1'b0;
                st_d.run  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.run     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o       = st_q.irq;
    assign user_mode_o = st_q.user;
    assign cnt_q       = st_q.cnt;
    assign run_q       = st_q.run;
endmodule

// File: rtl/dmt_checker.sv
`timescale 1ns/1ps
module dmt_checker #(
    parameter int CNT_W  = 63,
    parameter int FRAC_W = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             mode_stb_i,
    input logic             mode_bit_i,
    input logic             bus_wr_i,
    input logic             user_mode_o,
    input logic             irq_o,
    input logic             run_q,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1) << FRAC_W;

    // R9
    user_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        user_mode_o |-> !irq_o);

    // R12
    to_counter_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(user_mode_o) |-> (run_q && cnt_q == '0));

    // R11
    to_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(user_mode_o) |-> (!irq_o && cnt_q == '0));

    // R13
    same_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_stb_i && mode_bit_i == user_mode_o) |=> $stable(user_mode_o));

    // R9
    user_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_mode_o && !run_q && !bus_wr_i && !mode_stb_i) |=> $stable(cnt_q));

    // R2
    ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!user_mode_o && tick_i && !bus_wr_i && !mode_stb_i)
            |=> (cnt_q == $past(cnt_q) + STEP || cnt_q == '0));
endmodule

bind dual_mode_cpu_timer dmt_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .mode_stb_i  (mode_stb_i),
    .mode_bit_i  (mode_bit_i),
    .bus_wr_i    (bus_wr_i),
    .user_mode_o (user_mode_o),
    .irq_o       (irq_o),
    .run_q       (run_q),
    .cnt_q       (cnt_q)
);

// File: tb/tb_dual_mode_cpu_timer.sv
`timescale 1ns/1ps
module tb_dual_mode_cpu_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, mode_stb = 1'b0, mode_bit = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  word = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_s;
    logic        irq, user, irq_s, user_s;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    dual_mode_cpu_timer dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_stb_i(mode_stb),
        .mode_bit_i(mode_bit), .bus_wr_i(wr), .bus_rd_i(rd), .bus_word_i(word),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .user_mode_o(user)
    );

    dual_mode_cpu_timer #(.SYSTEM_TIMER(1'b1)) dut_sys (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_stb_i(mode_stb),
        .mode_bit_i(mode_bit), .bus_wr_i(wr), .bus_rd_i(rd), .bus_word_i(word),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_s), .irq_o(irq_s), .user_mode_o(user_s)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic w, input logic r,
                         input logic [2:0] wd, input logic [31:0] d);
        @(negedge clk);
        tick = t; wr = w; rd = r; word = wd; wdata = d;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
        tick = 0; wr = 0; rd = 0; mode_stb = 0;
    endtask

    task automatic rdw(input logic [2:0] wd, input logic [31:0] exp, input string tag);
        drive(0, 0, 1, wd, '0);
        #1 chk(tag, rdata, exp);
        settle();
    endtask

    task automatic wrw(input logic [2:0] wd, input logic [31:0] d);
        drive(0, 1, 0, wd, d);
        settle();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1, 0, 0, '0, '0);
            settle();
        end
    endtask

    task automatic set_mode(input logic b);
        @(negedge clk);
        mode_stb = 1'b1; mode_bit = b;
        settle();
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 mode", {31'b0, user}, 0);
        rdw(3, 1, "R1 run");
        rdw(1, 0, "R1 count");
        rdw(0, 0, "R1 limit");

        // R10 run word, both variants
        wrw(3, 0);
        drive(0, 0, 1, 3, '0);
        #1 chk("R10 run rd", rdata, 0);
        chk("R10 system word3", rdata_s, 0);
        settle();

        // R2 counter advances with run bit 0
        for (int k = 1; k <= 6; k++) begin
            ticks(1);
            rdw(1, k * 32'h200, "R2 step");
        end

        // R3/R4 limit sweep
        for (int L = 1; L <= 4; L++) begin
            wrw(0, (L << 9) | 32'h8000_01FF);
            rdw(0, L << 9, "R4 limit masked");
            ticks(L - 1);
            chk("R3 no irq before", {31'b0, irq}, 0);
            rdw(1, (L - 1) << 9, "R3 count before");
            ticks(1);
            chk("R3 irq at match", {31'b0, irq}, 1);
            rdw(1, 32'h8000_0000, "R3 wrap+reached");
            rdw(0, L << 9, "R5 ack read");
            chk("R5 irq cleared", {31'b0, irq}, 0);
            rdw(1, 0, "R5 reached cleared");
        end

        // R5 match and acknowledge in the same cycle
        wrw(0, 2 << 9);
        ticks(1);
        drive(1, 0, 1, 0, '0);
        #1 chk("R5 collide rd", rdata, 32'h400);
        settle();
        chk("R5 irq kept", {31'b0, irq}, 1);
        rdw(1, 32'h8000_0000, "R5 flag kept");
        rdw(0, 32'h400, "R5 second ack");
        chk("R5 irq gone", {31'b0, irq}, 0);

        // R6 soft limit and ignored word1 write
        wrw(0, 8 << 9);
        ticks(3);
        wrw(2, (5 << 9) | 32'h1FF);
        rdw(1, 32'h600, "R6 count kept");
        wrw(1, 32'h1234_5600);
        rdw(1, 32'h600, "R6 word1 ignored");
        ticks(1);
        chk("R6 no irq yet", {31'b0, irq}, 0);
        ticks(1);
        chk("R6 irq at new limit", {31'b0, irq}, 1);
        rdw(1, 32'h8000_0000, "R6 wrap");
        rdw(0, 32'hA00, "R6 limit");

        // R14 write with tick
        ticks(2);
        drive(1, 1, 0, 0, 3 << 9);
        settle();
        rdw(1, 0, "R14 write wins");
        ticks(1);
        rdw(1, 32'h200, "R14 resumes");

        // R3 limit 0 free runs without irq
        wrw(2, 0);
        ticks(4);
        chk("R3 free-run irq", {31'b0, irq}, 0);
        rdw(1, 32'hA00, "R3 free-run count");

        // R11 counter -> user with irq pending, run 0
        wrw(0, 1 << 9);
        ticks(1);
        chk("R11 irq pending", {31'b0, irq}, 1);
        set_mode(1);
        chk("R11 user", {31'b0, user}, 1);
        chk("R11 irq low", {31'b0, irq}, 0);
        chk("R10 system ignores mode", {31'b0, user_s}, 0);
        rdw(0, 0, "R11 upper/reached");
        rdw(1, 0, "R11 count");
        ticks(3);
        rdw(1, 0, "R11 halted");

        // R8/R9 user loads and counting with carry
        wrw(0, 32'h8000_0005);
        rdw(0, 5, "R8 upper");
        wrw(1, 32'hFFFF_FDFF);
        rdw(1, 32'hFFFF_FC00, "R8 lower masked");
        wrw(3, 1);
        for (int k = 1; k <= 4; k++) begin
            ticks(1);
            v = 64'h5_FFFF_FC00 + 64'(k) * 64'h200;
            rdw(0, v[63:32], "R9 upper");
            rdw(1, v[31:0], "R9 lower");
            chk("R9 no irq", {31'b0, irq}, 0);
        end
        wrw(3, 0);
        ticks(3);
        rdw(1, 32'h400, "R9 stopped");
        rdw(0, 6, "R9 stopped upper");

        // R9 wrap at maximum, R7 reads have no side effect
        wrw(0, 32'h7FFF_FFFF);
        wrw(1, 32'hFFFF_FC00);
        wrw(3, 1);
        ticks(1);
        rdw(0, 32'h8000_0000, "R9 wrap reached");
        rdw(1, 0, "R9 wrap count");
        chk("R9 wrap no irq", {31'b0, irq}, 0);
        rdw(0, 32'h8000_0000, "R7 read keeps flag");
        wrw(1, 32'h200);
        rdw(0, 0, "R8 flag cleared");
        rdw(1, 32'h200, "R8 lower");

        // R13 same-bit strobe and word 4 writes
        wrw(3, 0);
        set_mode(1);
        chk("R13 still user", {31'b0, user}, 1);
        rdw(1, 32'h200, "R13 count kept");
        wrw(4, 32'hFFFF_FFFF);
        rdw(0, 0, "R13 word4 upper");
        rdw(1, 32'h200, "R13 word4 lower");
        rdw(3, 0, "R13 word4 run");
        chk("R13 word4 mode", {31'b0, user}, 1);

        // R12 user -> counter
        set_mode(0);
        chk("R12 counter", {31'b0, user}, 0);
        rdw(3, 1, "R12 run forced");
        rdw(1, 0, "R12 count cleared");
        ticks(2);
        rdw(1, 32'h400, "R12 counting");
        chk("R12 no irq", {31'b0, irq}, 0);
        set_mode(0);
        rdw(1, 32'h400, "R13 counter same bit");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule